// File: doc/BRIEF.md
# DAC Two-Wire Target Front End

This block is the digital side of a single-channel 10-bit current-sink DAC. It listens on a two-wire serial bus (I2C) and answers a fixed address group. It stores a 16-bit data word that a bus master writes, and it presents a 10-bit code and a power-down flag to the analog core. It samples SCL and SDA with its own system clock and passes each line through a two-flop synchronizer. A digital filter then rejects short spikes before START, STOP and clock edges are decoded. The block pulls SDA low only through an open-drain enable and never drives it high.

A write is one address byte followed by a high data byte and then a low data byte, each sent MSB first. The DAC outputs change only once the low byte has arrived, so a frame that a STOP or a repeated START cuts short has no effect on them. A read returns the stored word, high byte first. Once both bytes have been read, the stored word is cleared. The flag to the analog core combines the soft power-down bit of the word with an asynchronous active-low shutdown pin.

Top module: `dac_i2c_target`

## Requirements
- R1: After reset, `dac_code` is 0, `dac_pd` is 0 (with `shdn_n` high) and `sda_oe` is 0. The outputs keep these values until a complete write.
- R2: A 7-bit address whose upper five bits are 00011 is accepted whatever its two low bits are. An address byte of 0x18 (write) or 0x1E (address 0x0F, write) is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: An address outside that group gets no acknowledge. SDA stays released and the DAC outputs do not change.
- R4: A write frame carries the address, then the high data byte, then the low data byte, each MSB first. Each data byte is acknowledged. Word bits 13..4 become `dac_code` (bit 13 is the MSB). Bits 14 and 3..0 have no effect.
- R5: `dac_code` and the soft power-down bit change only after the low data byte is complete. A frame that ends early, through a STOP or a repeated START, leaves both at their previous values.
- R6: Word bit 15 is an active-high soft power-down. When it is written as 1, `dac_pd` is 1.
- R7: While `shdn_n` is low, `dac_pd` is 1 whatever the stored power-down bit is. `dac_code` is unaffected.
- R8: A read addressed with 0x19 is acknowledged. The stored word then comes back high byte first, MSB first, in the same bit order as a write. A read does not change the DAC outputs.
- R9: After both bytes of a read have been clocked out, the stored word is all zeros, so the next read returns 0x00, 0x00.
- R10: A master NACK after a read byte ends transmission. SDA stays released until the next START, and the stored word is not cleared.
- R11: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` system clock cycles is ignored. A spike of this kind on SDA while SCL is high does not disturb a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| shdn_n | input | 1 | Asynchronous active-low shutdown |
| dac_code | output | CODE_W | Committed DAC code |
| dac_pd | output | 1 | Power-down request to the analog core |

## Verification
The bench attacks the address mask with both ends of the accepted group and one address just outside it. A decoder that compares all seven bits would fail to acknowledge 0x0F, and a loose one would acknowledge 0x0B. It cuts frames short with a STOP and with a repeated START, and it checks the outputs between the two data bytes. A design that commits byte by byte would show a half-written code there. It reads the same word twice, and it ends one read with a NACK. This exposes a missing clear, a clear applied on the wrong condition, and a target that keeps driving SDA after the master has refused a byte. Finally, it places a short SDA spike inside a high SCL phase. Without the filter, the spike would be decoded as a START and the write would be lost.

// File: rtl/dac_i2c_pkg.sv
// Package: shared encodings for the DAC two-wire target.
// Assumes a 16-bit data word with the power-down flag in its top bit.
package dac_i2c_pkg;
    localparam int WORD_W = 16;
    localparam int PD_BIT = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_RACK
    } tgt_state_t;
endpackage

// File: rtl/dac_i2c_deglitch.sv
// Module: two-flop synchronizer followed by a persistence filter.
// The output follows the input only after the synchronized value has differed
// from it for FILT_CYC consecutive clocks. Assumes the bus idles high.
module dac_i2c_deglitch #(
    parameter int FILT_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Bring the pad into the clock domain, then accept only persistent changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                dout  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dac_i2c_events.sv
// Module: decodes START, STOP and SCL edges from the filtered lines.
// Assumes both inputs are already synchronous and free of spikes.
module dac_i2c_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic bus_start,
    output logic bus_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    // Keep the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Classify the current sample pair.
    always_comb begin
        bus_start = scl_f && scl_d && sda_d && !sda_f;
        bus_stop  = scl_f && scl_d && !sda_d && sda_f;
        scl_rise  = scl_f && !scl_d;
        scl_fall  = !scl_f && scl_d;
    end
endmodule

// File: rtl/dac_i2c_target.sv
// Module: two-wire target that loads a DAC code and soft power-down flag.
// Assumes no clock stretching and a system clock much faster than SCL.
// The stored word is cleared after both bytes of a read are sent.
module dac_i2c_target
    import dac_i2c_pkg::*;
#(
    parameter int         FILT_CYC = 7,
    parameter logic [4:0] ADDR_HI  = 5'b00011,
    parameter int         CODE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              shdn_n,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_pd
);
    localparam int AHI_W    = $bits(ADDR_HI);
    localparam int CODE_LSB = PD_BIT - 1 - CODE_W;

    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    logic       bus_start, bus_stop, scl_rise, scl_fall;

    tgt_state_t        state;
    logic [3:0]        bit_cnt;
    logic [1:0]        byte_idx;
    logic [7:0]        rx_sh, tx_sh;
    logic              rw_q, mack_q, pd_q;
    logic [WORD_W-1:0] in_reg;
    logic [CODE_W-1:0] code_q;

    assign raw_lines = {scl_i, sda_i};

    // One filter lane per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        dac_i2c_deglitch #(.FILT_CYC(FILT_CYC)) i_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    dac_i2c_events i_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    // Protocol sequencer: receive, acknowledge, transmit and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            in_reg   <= '0;
            code_q   <= '0;
            pd_q     <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (bus_start) begin
            state    <= ST_RECV;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
        end else if (bus_stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RECV: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], sda_f};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (byte_idx == 2'd0) begin
                            if (rx_sh[7 -: AHI_W] == ADDR_HI) begin
                                rw_q   <= rx_sh[0];
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (byte_idx == 2'd1) begin
                            in_reg[WORD_W-1:8] <= rx_sh;
                            state  <= ST_ACK;
                            sda_oe <= 1'b1;
                        end else begin
                            in_reg[7:0] <= rx_sh;
                            code_q <= CODE_W'({in_reg[WORD_W-1:8], rx_sh} >> CODE_LSB);
                            pd_q   <= in_reg[PD_BIT];
                            state  <= ST_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (byte_idx == 2'd0 && rw_q) begin
                            state    <= ST_SEND;
                            byte_idx <= 2'd1;
                            tx_sh    <= in_reg[WORD_W-1:8];
                            sda_oe   <= ~in_reg[WORD_W-1];
                        end else if (byte_idx == 2'd2) begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end else begin
                            state    <= ST_RECV;
                            byte_idx <= byte_idx + 2'd1;
                            sda_oe   <= 1'b0;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            state   <= ST_RACK;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            sda_oe  <= ~tx_sh[6];
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (byte_idx == 2'd2) begin
                            in_reg <= '0;
                            state  <= ST_IDLE;
                        end else if (mack_q) begin
                            state    <= ST_SEND;
                            byte_idx <= 2'd2;
                            tx_sh    <= in_reg[7:0];
                            sda_oe   <= ~in_reg[7];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Analog-side outputs; the shutdown pin overrides the soft flag.
    assign dac_code = code_q;
    assign dac_pd   = pd_q | ~shdn_n;
endmodule

// File: rtl/dac_i2c_checker.sv
// Module: protocol checks for dac_i2c_target, attached with bind.
// Assumes the target's internal sequencer signal names.
module dac_i2c_checker
    import dac_i2c_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input logic        clk,
    input logic        rst_n,
    input tgt_state_t  state,
    input logic        sda_oe,
    input logic [3:0]  bit_cnt,
    input logic [1:0]  byte_idx,
    input logic        tx_msb,
    input logic [CODE_W:0] dac_word
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe); // R3

    AST_ACK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ACK |-> sda_oe); // R2

    AST_COMMIT_AFTER_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> $past(byte_idx) == 2'd2); // R5

    AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8); // R4

    AST_SEND_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEND |-> sda_oe == ~tx_msb); // R8
endmodule

bind dac_i2c_target dac_i2c_checker #(.CODE_W(CODE_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .sda_oe  (sda_oe),
    .bit_cnt (bit_cnt),
    .byte_idx(byte_idx),
    .tx_msb  (tx_sh[7]),
    .dac_word({pd_q, code_q})
);

// File: tb/test_dac_i2c_target.sv
// Bench: bus-master driver with a scoreboard of expected and observed values.
module test_dac_i2c_target;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       shdn_n = 1'b1;
    logic       sda_oe;
    logic [9:0] dac_code;
    logic       dac_pd;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    dac_i2c_target i_dac_i2c_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .shdn_n  (shdn_n),
        .dac_code(dac_code),
        .dac_pd  (dac_pd)
    );

    typedef struct {
        string req;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    act_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t cur_e;
    int    cur_a;

    // Monitor: pair each expected item with the next observation.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            cur_a = act_q.pop_front();
            n_chk++;
            if (cur_a != cur_e.val) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", cur_e.req, cur_a, cur_e.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int expv, input int actv);
        exp_q.push_back('{req, expv});
        act_q.push_back(actv);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic clk_bit(input logic b, input bit glitch, output logic got);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        if (glitch && b) begin
            tick(6); sda_m = 1'b0; tick(4); sda_m = 1'b1; tick(Q - 10);
        end else begin
            tick(Q);
        end
        got = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output bit acked);
        logic g;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], glitch, g);
        clk_bit(1'b1, 1'b0, g);
        acked = !g;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, g);
            d[i] = g;
        end
        clk_bit(!give_ack, 1'b0, g);
    endtask

    task automatic write_word(input logic [6:0] a, input logic [15:0] w, input bit glitch,
                              input string req);
        bit ak;
        bus_start();
        send_byte({a, 1'b0}, 1'b0, ak); check({req, " addr ack"}, 1, int'(ak));
        send_byte(w[15:8], glitch, ak); check("R4 high byte ack", 1, int'(ak));
        send_byte(w[7:0], 1'b0, ak);    check("R4 low byte ack", 1, int'(ak));
        bus_stop();
    endtask

    task automatic read_word(input string req, input logic [15:0] expw);
        bit ak;
        logic [7:0] d;
        bus_start();
        send_byte({7'h0C, 1'b1}, 1'b0, ak); check("R8 read addr ack", 1, int'(ak));
        recv_byte(1'b1, d); check({req, " high byte"}, int'(expw[15:8]), int'(d));
        recv_byte(1'b0, d); check({req, " low byte"}, int'(expw[7:0]), int'(d));
        bus_stop();
    endtask

    function automatic int word_out();
        return int'({dac_pd, dac_code});
    endfunction

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Driver: stimulus sequence with expected values from the requirements.
    initial begin
        bit ak;
        logic g;
        logic [7:0] d;
        tick(5); rst_n = 1'b1; tick(5);
        check("R1 reset dac", 0, word_out());
        check("R1 reset sda_oe", 0, int'(sda_oe));

        bus_start();
        send_byte({7'h0B, 1'b0}, 1'b0, ak); check("R3 foreign addr no ack", 0, int'(ak));
        clk_bit(1'b1, 1'b0, g); check("R3 sda released", 1, int'(g));
        bus_stop();
        check("R3 dac unchanged", 0, word_out());
        check("R1 dac held before write", 0, word_out());

        write_word(7'h0C, 16'h2A50, 1'b0, "R2 base");
        check("R4 code from bits 13..4", 10'h2A5, word_out());
        write_word(7'h0F, 16'h0137, 1'b0, "R2 top of group");
        check("R2 write via 0x0F", 10'h013, word_out());

        bus_start();
        send_byte(8'h18, 1'b0, ak);
        send_byte(8'h3F, 1'b0, ak);
        bus_stop();
        check("R5 stop abandons frame", 10'h013, word_out());

        bus_start();
        send_byte(8'h18, 1'b0, ak);
        send_byte(8'h11, 1'b0, ak);
        bus_start();
        send_byte(8'h18, 1'b0, ak);
        send_byte(8'h0F, 1'b0, ak);
        check("R5 unchanged between data bytes", 10'h013, word_out());
        send_byte(8'hF0, 1'b0, ak);
        bus_stop();
        check("R5 commit after repeated start", 10'h0FF, word_out());

        write_word(7'h0C, 16'h8010, 1'b0, "R6");
        check("R6 soft power-down set", 11'h401, word_out());
        write_word(7'h0C, 16'h400F, 1'b0, "R4");
        check("R4 bits 14 and 3..0 ignored", 0, word_out());

        write_word(7'h0C, 16'h1230, 1'b0, "R7");
        shdn_n = 1'b0; tick(2);
        check("R7 shutdown forces pd", 11'h523, word_out());
        shdn_n = 1'b1; tick(2);
        check("R7 release shutdown", 11'h123, word_out());

        write_word(7'h0C, 16'h5A60, 1'b0, "R8");
        read_word("R8 read", 16'h5A60);
        check("R8 read leaves dac", 11'h1A6, word_out());
        read_word("R9 read after clear", 16'h0000);

        write_word(7'h0C, 16'hC350, 1'b0, "R10");
        bus_start();
        send_byte(8'h19, 1'b0, ak);
        recv_byte(1'b0, d); check("R10 first byte", 8'hC3, int'(d));
        clk_bit(1'b1, 1'b0, g); check("R10 released after nack", 1, int'(g));
        bus_stop();
        read_word("R10 word kept after nack", 16'hC350);

        write_word(7'h0C, 16'h3FF0, 1'b1, "R11");
        check("R11 spike ignored", 10'h3FF, word_out());

        tick(5);
        while (exp_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            n_chk++; n_fail++;
            $display("FAIL %s: actual none expected 0x%0h", cur_e.req, cur_e.val);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule